// File: doc/BRIEF.md
# Complementary Gate Drive Sequencer

This block takes one logic command and drives two gate-enable outputs for a half bridge. The high-side output follows the command when it is high and the low-side output follows it when it is low. The two are never on together. Before either output turns on, the block waits a programmable dead time in which both outputs are low. It also checks a feedback line from the opposite driver, so that a driver still holding its gate high blocks the other side.

The command is synchronized first. Each run of the synchronized level is then measured in clock cycles and classified by its width. A short positive pulse can be dropped, or it can release only the low side. A long enough positive pulse turns the high side on and keeps it on for at least a minimum time. Negative pulses inside a high phase are sorted the same way, with their own limits. Because a run can only be classified once it has lasted long enough, the outputs lag the command by the classification window. A lockout input forces both outputs low. A low-side enable input turns synchronous low-side drive off without changing high-side behaviour.

Top module: `gdrv_seq`

## Requirements
- R1: After the settling delay, a steady low command gives ls_o=1 and hs_o=0. A steady high command, held longer than POS_HS_CYC, gives hs_o=1 and ls_o=0.
- R2: hs_o and ls_o are never both 1. Neither output rises unless both outputs were 0 for at least DEAD_CYC consecutive cycles just before it.
- R3: hs_o does not rise while ls_fb_i is 1, and ls_o does not rise while hs_fb_i is 1.
- R4: While the synchronized uvlo_i is 1, both outputs are 0 from the next cycle on. When it returns to 0, the outputs follow the command again.
- R5: While the synchronized ls_en_i is 0, ls_o stays 0 from the next cycle on. hs_o still follows the command.
- R6: A positive command pulse shorter than POS_IGN_CYC cycles changes neither output.
- R7: A positive pulse of at least POS_IGN_CYC and fewer than POS_HS_CYC cycles turns ls_o off for a time. hs_o stays 0.
- R8: A positive pulse of at least POS_HS_CYC cycles turns hs_o on. If the pulse ends before the stretch expires, hs_o stays high for exactly POS_STR_CYC cycles.
- R9: During a high phase, once the stretch has expired, a negative pulse shorter than NEG_IGN_CYC cycles changes neither output.
- R10: During a high phase, a negative pulse of at least NEG_IGN_CYC and fewer than NEG_LS_CYC cycles turns hs_o off for a time. ls_o stays 0.
- R11: During reset and in the first cycle after it, both outputs are 0. The sequencer holds both requests off for SYNC_STAGES cycles after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Switching command, asynchronous |
| ls_en_i | input | 1 | Low-side synchronous drive enable, asynchronous |
| uvlo_i | input | 1 | Undervoltage lockout; 1 forces both outputs off |
| hs_fb_i | input | 1 | Sensed level of the high-side gate |
| ls_fb_i | input | 1 | Sensed level of the low-side gate |
| hs_o | output | 1 | High-side gate enable |
| ls_o | output | 1 | Low-side gate enable |

## Verification
Two events can land on the same clock edge. The high-side stretch can expire in the cycle where a low run already exceeds both negative limits, so the sequencer jumps straight from the high phase to the low phase. A feedback interlock can also coincide with the end of the dead-time count. The first case is provoked by a positive pulse shorter than the stretch. The second is provoked by holding the low-side feedback high while the command asks for the high side, and then releasing it. A behavioural cycle model in the bench judges both cases on every clock. Window counters also check the exact high-side on-time and confirm that the blocked side never rises.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_LO    = 3'd1,
    ST_LSOFF = 3'd2,
    ST_HI    = 3'd3,
    ST_HSOFF = 3'd4
  } gdrv_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gdrv_pulse_class.sv
module gdrv_pulse_class
  import gdrv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POS_IGN_CYC = 3,
  parameter int POS_HS_CYC  = 6,
  parameter int POS_STR_CYC = 20,
  parameter int NEG_IGN_CYC = 2,
  parameter int NEG_LS_CYC  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic lock_i,
  input  logic ls_en_i,
  output logic hs_req_o,
  output logic ls_req_o
);
  localparam int RUN_MAX = imax(POS_HS_CYC, NEG_LS_CYC);
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int STR_W   = $clog2(POS_STR_CYC + 1);
  localparam int WAIT_W  = $clog2(SYNC_STAGES + 1);

  localparam logic [RUN_W-1:0]  RUN_TOP  = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0]  PIGN_TH  = RUN_W'(POS_IGN_CYC);
  localparam logic [RUN_W-1:0]  PHS_TH   = RUN_W'(POS_HS_CYC);
  localparam logic [RUN_W-1:0]  NIGN_TH  = RUN_W'(NEG_IGN_CYC);
  localparam logic [RUN_W-1:0]  NLS_TH   = RUN_W'(NEG_LS_CYC);
  localparam logic [STR_W-1:0]  STR_LOAD = STR_W'(POS_STR_CYC - 1);
  localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(SYNC_STAGES - 1);

  gdrv_state_e       st_q, st_n;
  logic [RUN_W-1:0]  run_q, run_n;
  logic [STR_W-1:0]  str_q, str_n;
  logic [WAIT_W-1:0] wait_q, wait_n;
  logic              cmd_d;

  // run length of the current level, including this cycle
  always_comb begin
    if (cmd_i != cmd_d)     run_n = RUN_W'(1);
    else if (run_q == RUN_TOP) run_n = run_q;
    else                    run_n = run_q + 1'b1;
  end

  always_comb begin
    st_n   = st_q;
    str_n  = str_q;
    wait_n = wait_q;
    if (st_q == ST_WAIT) begin
      if (wait_q == WAIT_END) st_n = ST_LO;
      else                    wait_n = wait_q + 1'b1;
    end else if (lock_i) begin
      st_n  = ST_LO;
      str_n = '0;
    end else begin
      unique case (st_q)
        ST_LO: begin
          if (cmd_i && run_n >= PHS_TH) begin
            st_n  = ST_HI;
            str_n = STR_LOAD;
          end else if (cmd_i && run_n >= PIGN_TH) begin
            st_n = ST_LSOFF;
          end
        end
        ST_LSOFF: begin
          if (!cmd_i) st_n = ST_LO;
          else if (run_n >= PHS_TH) begin
            st_n  = ST_HI;
            str_n = STR_LOAD;
          end
        end
        ST_HI: begin
          if (str_q != '0)                      str_n = str_q - 1'b1;
          else if (!cmd_i && run_n >= NLS_TH)   st_n  = ST_LO;
          else if (!cmd_i && run_n >= NIGN_TH)  st_n  = ST_HSOFF;
        end
        ST_HSOFF: begin
          if (cmd_i)                  st_n = ST_HI;
          else if (run_n >= NLS_TH)   st_n = ST_LO;
        end
        default: st_n = ST_LO;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_WAIT;
      run_q  <= RUN_TOP;
      str_q  <= '0;
      wait_q <= '0;
      cmd_d  <= 1'b0;
    end else begin
      st_q   <= st_n;
      run_q  <= run_n;
      str_q  <= str_n;
      wait_q <= wait_n;
      cmd_d  <= cmd_i;
    end
  end

  assign hs_req_o = (st_q == ST_HI) && !lock_i;
  assign ls_req_o = (st_q == ST_LO) && ls_en_i && !lock_i;
endmodule

// File: rtl/gdrv_interlock.sv
module gdrv_interlock #(
  parameter int DEAD_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_req_i,
  input  logic ls_req_i,
  input  logic hs_fb_i,
  input  logic ls_fb_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int DT_W = $clog2(DEAD_CYC + 1);
  localparam logic [DT_W-1:0] DT_TOP  = DT_W'(DEAD_CYC);
  localparam logic [DT_W-1:0] DT_OPEN = DT_W'(DEAD_CYC - 1);

  logic            hs_q, ls_q, idle, gap_ok;
  logic [DT_W-1:0] dt_q;

  assign idle   = !hs_q && !ls_q;
  assign gap_ok = idle && (dt_q >= DT_OPEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
      dt_q <= '0;
    end else begin
      if (!idle)              dt_q <= '0;
      else if (dt_q != DT_TOP) dt_q <= dt_q + 1'b1;
      // a side turns on only after the gap and with the other gate sensed low
      hs_q <= hs_req_i && (hs_q || (gap_ok && !ls_fb_i && !ls_req_i));
      ls_q <= ls_req_i && (ls_q || (gap_ok && !hs_fb_i && !hs_req_i));
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;
endmodule

// File: rtl/gdrv_seq.sv
module gdrv_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_CYC    = 3,
  parameter int POS_IGN_CYC = 3,
  parameter int POS_HS_CYC  = 6,
  parameter int POS_STR_CYC = 20,
  parameter int NEG_IGN_CYC = 2,
  parameter int NEG_LS_CYC  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic ls_en_i,
  input  logic uvlo_i,
  input  logic hs_fb_i,
  input  logic ls_fb_i,
  output logic hs_o,
  output logic ls_o
);
  logic [2:0] sync_q;
  logic       cmd_s, ls_en_s, lock_s;
  logic       hs_req, ls_req;

  gdrv_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (3)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({uvlo_i, ls_en_i, cmd_i}),
    .q_o   (sync_q)
  );

  assign cmd_s   = sync_q[0];
  assign ls_en_s = sync_q[1];
  assign lock_s  = sync_q[2];

  gdrv_pulse_class #(
    .SYNC_STAGES(SYNC_STAGES),
    .POS_IGN_CYC(POS_IGN_CYC),
    .POS_HS_CYC (POS_HS_CYC),
    .POS_STR_CYC(POS_STR_CYC),
    .NEG_IGN_CYC(NEG_IGN_CYC),
    .NEG_LS_CYC (NEG_LS_CYC)
  ) u_class (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_s),
    .lock_i  (lock_s),
    .ls_en_i (ls_en_s),
    .hs_req_o(hs_req),
    .ls_req_o(ls_req)
  );

  gdrv_interlock #(
    .DEAD_CYC(DEAD_CYC)
  ) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hs_req_i(hs_req),
    .ls_req_i(ls_req),
    .hs_fb_i (hs_fb_i),
    .ls_fb_i (ls_fb_i),
    .hs_o    (hs_o),
    .ls_o    (ls_o)
  );
endmodule

// File: rtl/gdrv_seq_chk.sv
module gdrv_seq_chk #(
  parameter int DEAD_CYC = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hs_o,
  input logic ls_o,
  input logic hs_fb_i,
  input logic ls_fb_i,
  input logic lock_s,
  input logic ls_en_s
);
  logic [7:0] lo_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             lo_run <= '0;
    else if (hs_o || ls_o)   lo_run <= '0;
    else if (lo_run != 8'hFF) lo_run <= lo_run + 1'b1;
  end

  // R2
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));
  // R2
  hs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> (lo_run >= 8'(DEAD_CYC)));
  // R2
  ls_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_o) |-> (lo_run >= 8'(DEAD_CYC)));
  // R3
  hs_fb_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> !$past(ls_fb_i));
  // R3
  ls_fb_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_o) |-> !$past(hs_fb_i));
  // R4
  lockout_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_s |=> (!hs_o && !ls_o));
  // R5
  ls_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ls_en_s |=> !ls_o);
endmodule

bind gdrv_seq gdrv_seq_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .hs_o   (hs_o),
  .ls_o   (ls_o),
  .hs_fb_i(hs_fb_i),
  .ls_fb_i(ls_fb_i),
  .lock_s (lock_s),
  .ls_en_s(ls_en_s)
);

// File: tb/sim_gdrv_seq.sv
module sim_gdrv_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD  = 3;
  localparam int PIGN  = 3;
  localparam int PHS   = 6;
  localparam int PSTR  = 20;
  localparam int NIGN  = 2;
  localparam int NLS   = 5;
  localparam int RUNMX = (PHS > NLS) ? PHS : NLS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd = 1'b0, en = 1'b1, uv = 1'b0, ls_stuck = 1'b0;
  logic hs_o, ls_o, hs_fb, ls_fb;
  int   compared = 0, fails = 0;
  bit   done = 1'b0, cmp_on = 1'b0;
  string cur_req = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  assign hs_fb = hs_o;
  assign ls_fb = ls_stuck | ls_o;

  gdrv_seq #(
    .SYNC_STAGES(2), .DEAD_CYC(DEAD), .POS_IGN_CYC(PIGN), .POS_HS_CYC(PHS),
    .POS_STR_CYC(PSTR), .NEG_IGN_CYC(NIGN), .NEG_LS_CYC(NLS)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .ls_en_i(en), .uvlo_i(uv),
    .hs_fb_i(hs_fb), .ls_fb_i(ls_fb), .hs_o(hs_o), .ls_o(ls_o)
  );

  // behavioural reference: 0 wait, 1 low, 2 low side released, 3 high, 4 high side released
  int m_mode, m_run, m_str, m_wait, m_dt;
  bit m_hs, m_ls, m_sd;
  bit a_c, a_e, a_u, b_c, b_e, b_u;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_run = RUNMX; m_str = 0; m_wait = 0; m_dt = 0;
      m_hs = 0; m_ls = 0; m_sd = 0;
      a_c = 0; a_e = 0; a_u = 0; b_c = 0; b_e = 0; b_u = 0;
    end else begin
      bit s, lk, ok, want_h, want_l, quiet, open, nh, nl;
      int rn, nmode, nstr, nwait;
      s = b_c; lk = b_u; ok = b_e;
      want_h = (m_mode == 3) && !lk;
      want_l = (m_mode == 1) && ok && !lk;
      quiet  = !m_hs && !m_ls;
      open   = quiet && (m_dt >= DEAD - 1);
      nh = want_h && (m_hs || (open && !(ls_stuck || m_ls) && !want_l));
      nl = want_l && (m_ls || (open && !m_hs && !want_h));
      m_dt = quiet ? ((m_dt < DEAD) ? m_dt + 1 : m_dt) : 0;
      m_hs = nh; m_ls = nl;
      rn = (s != m_sd) ? 1 : ((m_run < RUNMX) ? m_run + 1 : m_run);
      nmode = m_mode; nstr = m_str; nwait = m_wait;
      if (m_mode == 0) begin
        if (m_wait == 1) nmode = 1; else nwait = m_wait + 1;
      end else if (lk) begin
        nmode = 1; nstr = 0;
      end else if (m_mode == 1) begin
        if (s && rn >= PHS) begin nmode = 3; nstr = PSTR - 1; end
        else if (s && rn >= PIGN) nmode = 2;
      end else if (m_mode == 2) begin
        if (!s) nmode = 1;
        else if (rn >= PHS) begin nmode = 3; nstr = PSTR - 1; end
      end else if (m_mode == 3) begin
        if (m_str > 0) nstr = m_str - 1;
        else if (!s && rn >= NLS) nmode = 1;
        else if (!s && rn >= NIGN) nmode = 4;
      end else begin
        if (s) nmode = 3;
        else if (rn >= NLS) nmode = 1;
      end
      m_mode = nmode; m_str = nstr; m_wait = nwait;
      m_sd = s; m_run = rn;
      b_c = a_c; b_e = a_e; b_u = a_u;
      a_c = cmd; a_e = en; a_u = uv;
    end
  end

  // per-cycle comparison and dead-gap monitor
  int both_lo = 0, gap_bad = 0, overlap = 0;
  bit p_hs = 0, p_ls = 0;
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      compared++;
      if (hs_o !== m_hs || ls_o !== m_ls) begin
        fails++;
        $display("FAIL %s cycle compare: hs_o=%0b ls_o=%0b expected hs=%0b ls=%0b",
                 cur_req, hs_o, ls_o, m_hs, m_ls);
      end
      if (hs_o && ls_o) overlap++;
      if ((hs_o && !p_hs) || (ls_o && !p_ls)) if (both_lo < DEAD) gap_bad++;
      both_lo = (!hs_o && !ls_o) ? both_lo + 1 : 0;
      p_hs = hs_o; p_ls = ls_o;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int w_hs_hi, w_ls_hi, w_hs_lo, w_ls_lo, w_hs_max, hs_cur;

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // window: base level for pre cycles, lvl for w cycles, base for post cycles
  task automatic seq_win(input int pre, input int w, input bit lvl, input int post);
    w_hs_hi = 0; w_ls_hi = 0; w_hs_lo = 0; w_ls_lo = 0; w_hs_max = 0; hs_cur = 0;
    for (int i = 0; i < pre + w + post; i++) begin
      @(negedge clk);
      if (hs_o) begin w_hs_hi++; hs_cur++; end else hs_cur = 0;
      if (hs_cur > w_hs_max) w_hs_max = hs_cur;
      if (ls_o) w_ls_hi++; else w_ls_lo++;
      if (!hs_o) w_hs_lo++;
      cmd = (i >= pre && i < pre + w) ? lvl : !lvl;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "hs_o in reset", hs_o, 0);
    chk("R11", "ls_o in reset", ls_o, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    chk("R11", "ls_o first cycle", ls_o, 0);
    settle(10);
    cur_req = "R1";
    chk("R1", "ls_o low command", ls_o, 1);
    chk("R1", "hs_o low command", hs_o, 0);

    cur_req = "R6";
    seq_win(5, 2, 1'b1, 20);
    chk("R6", "ls_o low cycles", w_ls_lo, 0);
    chk("R6", "hs_o high cycles", w_hs_hi, 0);

    cur_req = "R7";
    seq_win(5, 4, 1'b1, 20);
    chk("R7", "ls_o released", (w_ls_lo > 0) ? 1 : 0, 1);
    chk("R7", "hs_o high cycles", w_hs_hi, 0);

    cur_req = "R8";
    seq_win(5, 8, 1'b1, 40);
    chk("R8", "hs_o stretched width", w_hs_max, PSTR);

    cur_req = "R1";
    seq_win(5, 60, 1'b1, 30);
    chk("R1", "hs_o long high run", (w_hs_max >= 50) ? 1 : 0, 1);

    cmd = 1'b1;
    settle(40);
    chk("R1", "hs_o steady high", hs_o, 1);
    chk("R1", "ls_o steady high", ls_o, 0);

    cur_req = "R9";
    seq_win(5, 1, 1'b0, 20);
    chk("R9", "hs_o low cycles", w_hs_lo, 0);
    chk("R9", "ls_o high cycles", w_ls_hi, 0);

    cur_req = "R10";
    seq_win(5, 3, 1'b0, 20);
    chk("R10", "hs_o released", (w_hs_lo > 0) ? 1 : 0, 1);
    chk("R10", "ls_o high cycles", w_ls_hi, 0);
    cmd = 1'b0;
    settle(30);

    cur_req = "R5";
    en = 1'b0;
    settle(10);
    seq_win(10, 40, 1'b1, 30);
    chk("R5", "ls_o high while disabled", w_ls_hi, 0);
    chk("R5", "hs_o still follows", (w_hs_hi > 0) ? 1 : 0, 1);
    en = 1'b1;
    settle(15);
    chk("R5", "ls_o after re-enable", ls_o, 1);

    cur_req = "R4";
    uv = 1'b1;
    settle(5);
    seq_win(5, 40, 1'b1, 30);
    chk("R4", "hs_o high in lockout", w_hs_hi, 0);
    chk("R4", "ls_o high in lockout", w_ls_hi, 0);
    uv = 1'b0;
    settle(15);
    chk("R4", "ls_o after release", ls_o, 1);

    cur_req = "R3";
    ls_stuck = 1'b1;
    seq_win(5, 40, 1'b1, 0);
    chk("R3", "hs_o high with feedback stuck", w_hs_hi, 0);
    ls_stuck = 1'b0;
    settle(10);
    chk("R3", "hs_o after feedback clears", hs_o, 1);
    cmd = 1'b0;
    settle(30);

    cur_req = "R2";
    chk("R2", "overlap cycles", overlap, 0);
    chk("R2", "short dead gaps", gap_bad, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, fails);
      $finish;
    end
  end
endmodule